// File: doc/BRIEF.md
# Mapped-Vector Interrupt Controller

This block collects up to 64 active-low interrupt request lines and presents them to a processor through a small register window and a single interrupt output. Each source number is routed to a fixed bit of either a "high" or a "low" pending word. The same position in the matching mask word gates that source. The routing does not follow source arithmetic. It uses a fixed irregular table, so software needs the table below to touch the right bit.

Sources fall into three sense groups. Internal sources are plain active-low levels. External sources 19 to 25 can be active-low levels or falling edges. Port sources 48 to 63 can be falling-edge only or both-edge. Every external and port line passes through a two-stage synchronizer before it is sensed. Edge events latch until software writes a 1 to their pending position. A read-only vector word gives the lowest-numbered source that is pending and unmasked, with source 1 having the highest priority. Source number 0 is reserved for "nothing pending".

The bus is a plain single-cycle port with no back-pressure. A write completes in the cycle it is presented. Read data appears one clock after the address. Register addresses: 0 pending high, 1 pending low, 2 mask high, 3 mask low, 4 edge-select, 5 vector.

Top module: `vecmap_intc`

## Requirements
- R1: After reset, the pending words, mask words, edge-select word, vector word and read data are all zero, and `irq_o` is low.
- R2: Sources are routed to word bits as follows.
  - Source 0 maps to high bit 0.
  - Sources 1–15 map to high bit 16−s.
  - Sources 32–47 map to high bit 63−s.
  - Sources 16–18 map to low bit 18−s.
  - Sources 19–30 map to low bit 33−s.
  - Source 31 maps to low bit 0.
  - Sources 48–63 map to low bit s−32.
  - Low bit 15 has no source and reads 0.
- R3: A mask bit of 1 enables the source or sources at that position, and a 0 blocks them. Mask words read back as written. `irq_o` is high exactly when some source 1–63 is pending and enabled, one clock after the state that causes it.
- R4: Internal sources are active-low levels. The pending bit equals the inverted line as sampled at the previous clock. Writing 1 to clear it has no lasting effect while the line stays low.
- R5: External sources 19–25 use edge-select bit 33−s. With that bit at 1, a falling edge sets a sticky pending bit. With it at 0, pending follows the low level. Either way the result appears three clocks after the line changes.
- R6: Port sources 48–63 use edge-select bit s−32. With that bit at 1, only falling edges set pending. With it at 0 (the reset value), both edges set pending. Port pending is always sticky.
- R7: Writing a word to pending address 0 or 1 clears each sticky source whose position holds a 1 and leaves every other source unchanged. Writing all ones to both words clears every latched edge.
- R8: Reading address 5 returns the lowest-numbered pending and enabled source among 1–63 in bits 31:26, with bits 25:0 zero. The whole word is 0 when no source qualifies.
- R9: Source 0 shows in pending high bit 0 but never raises `irq_o` and is never reported in the vector.
- R10: Sources 18 and 31 share low bit 0. The pending bit shows either of them, one mask bit gates both, and the vector reports 18 ahead of 31.
- R11: An edge event in the same clock as a clear of its position leaves the pending bit set.
- R12: Addresses 6 and 7 read 0. Edge-select bits other than 8–14 and 16–31 are not implemented and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Active-low request lines, bit n is source n |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acts in the cycle it is high |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| irq_o | output | 1 | High while any enabled source 1–63 is pending |

## Verification
The timing of each result is fixed:

- An internal level shows in pending state one rising edge after the line moves.
- An external or port line needs three rising edges: two synchronizer stages and the sense register.
- Mask writes and clears act on the first rising edge after they are presented.
- `irq_o` follows pending and mask state with no extra delay.
- A read returns the state as it stood at the edge that captured the address.

The bench drives inputs just after a falling edge. It steps a behavioural model on every rising edge and compares `irq_o` and `bus_rdata` at the next falling edge. Directed reads are made only after the line-to-pending latency has run out.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
  localparam int NSRC   = 64;
  localparam int WORD_W = 32;

  localparam int EXT_FIRST  = 19;
  localparam int EXT_LAST   = 25;
  localparam int PORT_FIRST = 48;
  localparam int PORT_LAST  = 63;

  typedef enum logic [1:0] {
    SK_INT  = 2'd0,
    SK_EXT  = 2'd1,
    SK_PORT = 2'd2
  } sense_kind_e;

  typedef enum logic [2:0] {
    RA_PEND_HI = 3'd0,
    RA_PEND_LO = 3'd1,
    RA_MASK_HI = 3'd2,
    RA_MASK_LO = 3'd3,
    RA_ESEL    = 3'd4,
    RA_VECT    = 3'd5
  } reg_addr_e;

  function automatic sense_kind_e src_kind(input int s);
    if (s >= EXT_FIRST && s <= EXT_LAST) return SK_EXT;
    if (s >= PORT_FIRST && s <= PORT_LAST) return SK_PORT;
    return SK_INT;
  endfunction

  // R2: word selection for a source
  function automatic bit src_in_hi(input int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  // R2: bit position inside the selected word
  function automatic int src_bitpos(input int s);
    if (s == 0)  return 0;
    if (s < 16)  return 16 - s;
    if (s < 19)  return 18 - s;
    if (s < 31)  return 33 - s;
    if (s == 31) return 0;
    if (s < 48)  return 63 - s;
    return s - 32;
  endfunction

  // R5/R6: edge-select bit of a programmable source
  function automatic int esel_pos(input int s);
    if (src_kind(s) == SK_EXT) return 33 - s;
    return s - 32;
  endfunction

  function automatic logic [WORD_W-1:0] esel_impl();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (src_kind(s) != SK_INT) m[esel_pos(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/vmi_sync.sv
module vmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vmi_sense_cell.sv
module vmi_sense_cell
  import vmi_pkg::*;
#(
  parameter sense_kind_e KIND = SK_INT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,    // request active, high-true
  input  logic esel,   // edge-select bit for this source
  input  logic clr,    // write-one-to-clear strobe for this source
  output logic pend
);
  logic prev_q;
  logic level_mode;
  logic rise_only;
  logic evt;

  always_comb begin
    level_mode = (KIND == SK_INT) || ((KIND == SK_EXT) && !esel);
    rise_only  = (KIND != SK_PORT) || esel;
    evt        = rise_only ? (act & ~prev_q) : (act ^ prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= act;
      // level: follow the line; edge: sticky, event wins over clear (R11)
      pend   <= level_mode ? act : ((pend & ~clr) | evt);
    end
  end
endmodule

// File: rtl/vmi_prio.sv
module vmi_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan downwards so the last hit is the lowest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vmi_regs.sv
module vmi_regs
  import vmi_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [DATA_W-1:0] pend_hi,
  input  logic [DATA_W-1:0] pend_lo,
  input  logic [IDX_W-1:0]  vec_idx,
  output logic [DATA_W-1:0] mask_hi,
  output logic [DATA_W-1:0] mask_lo,
  output logic [DATA_W-1:0] esel,
  output logic              clr_hi,
  output logic              clr_lo,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] ESEL_MASK = DATA_W'(esel_impl());
  localparam int PAD_W = DATA_W - IDX_W;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    clr_hi = we && (addr == ADDR_W'(RA_PEND_HI));
    clr_lo = we && (addr == ADDR_W'(RA_PEND_LO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi <= '0;
      mask_lo <= '0;
      esel    <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(RA_MASK_HI)) mask_hi <= wdata;
      if (addr == ADDR_W'(RA_MASK_LO)) mask_lo <= wdata;
      if (addr == ADDR_W'(RA_ESEL))    esel    <= wdata & ESEL_MASK;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(RA_PEND_HI): rd_mux = pend_hi;
      ADDR_W'(RA_PEND_LO): rd_mux = pend_lo;
      ADDR_W'(RA_MASK_HI): rd_mux = mask_hi;
      ADDR_W'(RA_MASK_LO): rd_mux = mask_lo;
      ADDR_W'(RA_ESEL):    rd_mux = esel;
      ADDR_W'(RA_VECT):    rd_mux = {vec_idx, {PAD_W{1'b0}}};
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end
endmodule

// File: rtl/vecmap_intc.sv
module vecmap_intc
  import vmi_pkg::*;
#(
  parameter int DATA_W      = WORD_W,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]   act;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   esel_src;
  logic [NSRC-1:0]   clr_src;
  logic [NSRC-1:0]   req;
  logic [DATA_W-1:0] pend_hi, pend_lo;
  logic [DATA_W-1:0] mask_hi, mask_lo;
  logic [DATA_W-1:0] esel_q;
  logic              clr_hi, clr_lo;
  logic [IDX_W-1:0]  vec_idx;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam sense_kind_e KIND  = src_kind(s);
    localparam bit          IN_HI = src_in_hi(s);
    localparam int          BITP  = src_bitpos(s);

    if (KIND == SK_INT) begin : g_direct
      assign act[s]      = ~src_n[s];
      assign esel_src[s] = 1'b0;
    end else begin : g_synced
      localparam int EPOS = esel_pos(s);
      vmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~src_n[s]),
        .q     (act[s])
      );
      assign esel_src[s] = esel_q[EPOS];
    end

    if (IN_HI) begin : g_hi
      assign clr_src[s] = clr_hi & bus_wdata[BITP];
    end else begin : g_lo
      assign clr_src[s] = clr_lo & bus_wdata[BITP];
    end

    vmi_sense_cell #(.KIND(KIND)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act[s]),
      .esel  (esel_src[s]),
      .clr   (clr_src[s]),
      .pend  (pend[s])
    );

    if (s == 0) begin : g_rsvd
      assign req[s] = 1'b0;    // R9: source 0 never requests
    end else if (IN_HI) begin : g_req_hi
      assign req[s] = pend[s] & mask_hi[BITP];
    end else begin : g_req_lo
      assign req[s] = pend[s] & mask_lo[BITP];
    end
  end

  // R2/R10: word views, shared positions show either source
  always_comb begin
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_in_hi(s)) pend_hi[src_bitpos(s)] |= pend[s];
      else              pend_lo[src_bitpos(s)] |= pend[s];
    end
  end

  vmi_prio #(.N(NSRC), .IW(IDX_W)) u_prio (
    .req (req),
    .any (irq_o),
    .idx (vec_idx)
  );

  vmi_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .we      (bus_we),
    .pend_hi (pend_hi),
    .pend_lo (pend_lo),
    .vec_idx (vec_idx),
    .mask_hi (mask_hi),
    .mask_lo (mask_lo),
    .esel    (esel_q),
    .clr_hi  (clr_hi),
    .clr_lo  (clr_lo),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/vmi_chk.sv
module vmi_chk
  import vmi_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              probe_n,   // line of internal source 40
  input logic              irq_o,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       wd_up,     // write data bits 31:16
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NSRC-1:0]   pend,
  input logic [DATA_W-1:0] mask_hi,
  input logic [DATA_W-1:0] mask_lo,
  input logic              clr_lo
);
  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend[40] == !$past(probe_n)));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hi == '0 && mask_lo == '0) |-> !irq_o);

  assert_src0_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NSRC-1:1] == '0 && pend[0]) |-> !irq_o);

  assert_idle_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(RA_VECT) && !irq_o) |=> (bus_rdata == '0));

  assert_shared_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[18] && mask_lo[0]) |-> irq_o);

  for (genvar s = PORT_FIRST; s <= PORT_LAST; s++) begin : g_sticky
    assert_port_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[s] && !(clr_lo && wd_up[s-PORT_FIRST])) |=> pend[s]);
  end
endmodule

bind vecmap_intc vmi_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .probe_n   (src_n[40]),
  .irq_o     (irq_o),
  .bus_addr  (bus_addr),
  .wd_up     (bus_wdata[31:16]),
  .bus_rdata (bus_rdata),
  .pend      (pend),
  .mask_hi   (mask_hi),
  .mask_lo   (mask_lo),
  .clr_lo    (clr_lo)
);

// File: tb/vecmap_intc_tb_top.sv
module vecmap_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_n;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic        irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    run_cmp = 1'b0;
  bit    done    = 1'b0;
  string phase   = "R1";

  always #5 clk = ~clk;

  vecmap_intc dut_i (
    .clk (clk), .rst_n (rst_n), .src_n (src_n),
    .bus_addr (addr), .bus_wdata (wdata), .bus_we (we),
    .bus_rdata (rdata), .irq_o (irq)
  );

  // ---------------- specification helpers ----------------
  function automatic bit f_hi(int s);
    return (s <= 15) || (s >= 32 && s <= 47);
  endfunction
  function automatic int f_bit(int s);
    if (s == 0) return 0;
    if (s <= 15) return 16 - s;
    if (s <= 18) return 18 - s;
    if (s <= 30) return 33 - s;
    if (s == 31) return 0;
    if (s <= 47) return 63 - s;
    return s - 32;
  endfunction
  function automatic int f_kind(int s);   // 0 internal, 1 external, 2 port
    if (s >= 19 && s <= 25) return 1;
    if (s >= 48) return 2;
    return 0;
  endfunction
  function automatic int f_epos(int s);
    return (f_kind(s) == 1) ? 33 - s : s - 32;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit          m_pend [64];
  bit          m_a1   [64];
  bit          m_a2   [64];
  bit          m_prev [64];
  logic [31:0] m_mhi, m_mlo, m_esel, m_rd;

  function automatic logic [31:0] m_pword(bit hi);
    logic [31:0] w = '0;
    for (int s = 0; s < 64; s++)
      if (f_hi(s) == hi && m_pend[s]) w[f_bit(s)] = 1'b1;
    return w;
  endfunction
  function automatic int m_vec();
    for (int s = 1; s < 64; s++) begin
      if (m_pend[s] && (f_hi(s) ? m_mhi[f_bit(s)] : m_mlo[f_bit(s)])) return s;
    end
    return 0;
  endfunction
  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [31:0] v;
    case (a)
      3'd0: return m_pword(1'b1);
      3'd1: return m_pword(1'b0);
      3'd2: return m_mhi;
      3'd3: return m_mlo;
      3'd4: return m_esel;
      3'd5: begin v = 32'(m_vec()); return v << 26; end
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    bit          np [64];
    bit          raw, es, evt, clr;
    int          k;
    logic [31:0] nrd;
    if (!rst_n) begin
      for (int s = 0; s < 64; s++) begin
        m_pend[s] = 0; m_a1[s] = 0; m_a2[s] = 0; m_prev[s] = 0;
      end
      m_mhi = '0; m_mlo = '0; m_esel = '0; m_rd = '0;
    end else begin
      nrd = m_read(addr);
      for (int s = 0; s < 64; s++) begin
        raw = !src_n[s];
        k   = f_kind(s);
        clr = we && ((f_hi(s) && addr == 3'd0) || (!f_hi(s) && addr == 3'd1))
                 && wdata[f_bit(s)];
        if (k == 0) begin
          np[s] = raw;
        end else begin
          es = m_esel[f_epos(s)];
          if (k == 1 && !es) np[s] = m_a2[s];
          else begin
            evt   = (k == 1 || es) ? (m_a2[s] && !m_prev[s]) : (m_a2[s] != m_prev[s]);
            np[s] = (m_pend[s] && !clr) || evt;
          end
          m_prev[s] = m_a2[s];
          m_a2[s]   = m_a1[s];
          m_a1[s]   = raw;
        end
      end
      if (we) begin
        if (addr == 3'd2) m_mhi  = wdata;
        if (addr == 3'd3) m_mlo  = wdata;
        if (addr == 3'd4) m_esel = wdata & 32'hFFFF_7F00;
      end
      for (int s = 0; s < 64; s++) m_pend[s] = np[s];
      m_rd = nrd;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(phase, "model irq", {31'b0, irq}, {31'b0, m_vec() != 0});
      chk(phase, "model rdata", rdata, m_rd);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1; we = 1'b0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1; addr = a;
    @(negedge clk); v = rdata;
  endtask
  task automatic line(int s, bit v);
    @(negedge clk); #1; src_n[s] = v;
  endtask
  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1-run actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; src_n = '1; we = 1'b0; addr = '0; wdata = '0;
    settle(3);
    #1 rst_n = 1'b1;
    run_cmp = 1'b1;

    // R1: reset state
    phase = "R1";
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1", "reset read", v, 32'h0);
    end
    chk("R1", "reset irq", {31'b0, irq}, 32'h0);

    // R2: routing of several sources
    phase = "R2";
    line(5, 0); line(40, 0); line(20, 0); line(50, 0);
    settle(4);
    rd(3'd0, v); chk("R2", "pend hi src5/40", v, 32'h0080_0800);
    rd(3'd1, v); chk("R2", "pend lo src20/50", v, 32'h0004_2000);
    chk("R3", "masked irq", {31'b0, irq}, 32'h0);

    // R3: mask enables
    phase = "R3";
    wr(3'd2, 32'h0000_0800);
    settle(1);
    chk("R3", "unmasked irq", {31'b0, irq}, 32'h1);
    rd(3'd2, v); chk("R3", "mask readback", v, 32'h0000_0800);
    rd(3'd5, v); chk("R8", "vector src5", v, 32'h1400_0000);

    // R8: lowest number wins
    phase = "R8";
    line(3, 0);
    wr(3'd2, 32'h0000_2800);
    settle(2);
    rd(3'd5, v); chk("R8", "vector src3", v, 32'h0C00_0000);
    wr(3'd3, 32'h0000_2000);
    wr(3'd2, 32'h0);
    rd(3'd5, v); chk("R8", "vector src20", v, 32'h5000_0000);

    // R4: level clear has no lasting effect
    phase = "R4";
    line(3, 1);
    settle(2);
    wr(3'd0, 32'h0000_0800);
    settle(1);
    rd(3'd0, v); chk("R4", "level survives clear", v, 32'h0080_0800);
    line(5, 1);
    settle(2);
    rd(3'd0, v); chk("R4", "level released", v, 32'h0080_0000);

    // R5: external falling edge, sticky
    phase = "R5";
    wr(3'd4, 32'h0000_1000);
    line(21, 0); settle(2); line(21, 1);
    settle(4);
    rd(3'd1, v); chk("R5", "ext edge latched", v, 32'h0004_3000);
    wr(3'd1, 32'h0000_1000);
    rd(3'd1, v); chk("R7", "ext edge cleared", v, 32'h0004_2000);

    // R6: port both-edge then falling-only
    phase = "R6";
    line(55, 0); settle(4);
    rd(3'd1, v); chk("R6", "port fall both-mode", v, 32'h0084_2000);
    wr(3'd1, 32'h0080_0000);
    line(55, 1); settle(4);
    rd(3'd1, v); chk("R6", "port rise both-mode", v, 32'h0084_2000);
    wr(3'd1, 32'h0080_0000);
    wr(3'd4, 32'h0080_1000);
    line(55, 0); settle(4);
    wr(3'd1, 32'h0080_0000);
    line(55, 1); settle(4);
    rd(3'd1, v); chk("R6", "port rise ignored fall-only", v, 32'h0004_2000);

    // R11: event coinciding with clear
    phase = "R11";
    line(56, 0); settle(4);
    @(negedge clk); #1; src_n[56] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1; we = 1'b1; addr = 3'd1; wdata = 32'h0100_0000;
    @(negedge clk); #1; we = 1'b0;
    rd(3'd1, v); chk("R11", "event beats clear", v, 32'h0104_2000);
    wr(3'd1, 32'h0100_0000);
    rd(3'd1, v); chk("R7", "plain clear", v, 32'h0004_2000);

    // R7: clear everything
    phase = "R7";
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R7", "all-ones lo keeps level", v, 32'h0000_2000);
    rd(3'd0, v); chk("R7", "all-ones hi keeps level", v, 32'h0080_0000);

    // R9: source 0 reserved
    phase = "R9";
    @(negedge clk); #1; src_n = '1;
    settle(4);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_0001);
    line(0, 0); settle(2);
    rd(3'd0, v); chk("R9", "src0 pending", v, 32'h0000_0001);
    chk("R9", "src0 no irq", {31'b0, irq}, 32'h0);
    rd(3'd5, v); chk("R9", "src0 no vector", v, 32'h0);

    // R10: shared low bit 0
    phase = "R10";
    line(0, 1);
    wr(3'd3, 32'h0000_0001);
    line(31, 0); settle(2);
    rd(3'd5, v); chk("R10", "vector src31", v, 32'h7C00_0000);
    line(18, 0); settle(2);
    rd(3'd5, v); chk("R10", "vector src18 first", v, 32'h4800_0000);
    rd(3'd1, v); chk("R10", "shared pend bit", v, 32'h0000_0001);
    wr(3'd3, 32'h0);
    chk("R10", "shared mask off", {31'b0, irq}, 32'h0);

    // R12: unused addresses and edge-select bits
    phase = "R12";
    rd(3'd6, v); chk("R12", "addr 6", v, 32'h0);
    rd(3'd7, v); chk("R12", "addr 7", v, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R12", "esel implemented", v, 32'hFFFF_7F00);

    settle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule